// File: doc/BRIEF.md
# PHY Event Interrupt Aggregator

This block gathers single-cycle event pulses from an Ethernet transceiver's internal logic into a sticky pending register. It drives one active-low interrupt line toward the management host. The host reaches two 16-bit registers through a plain read/write strobe port: a mask register and a pending register. Both use the same bit layout. Each event owns a fixed bit in that layout, and the bits are spread unevenly across the 16 positions.

A pending bit latches whenever its event fires, whether or not its mask bit is set. The interrupt line goes low only while a bit is both pending and unmasked. Reading the pending register returns its contents and empties it in the same access, so the read also serves as the acknowledge. An event that arrives in the same cycle as that read is not lost. The line is registered, so it follows the pending and mask state one clock later.

Top module: `phy_irq_agg`

## Requirements
- R1: Writing address 0x12 loads the mask register, and reading 0x12 returns it. Only the bit positions 15..10, 5, 1 and 0 (mask 0xFC23) can be written.
- R2: Each pulse on `evt_i[k]` sets one bit of the pending register, which reads at address 0x13. The mapping is k=0 to bit 0 (wake match), k=1 to bit 1 (polarity change), k=2 to bit 5 (speed downgrade), and k=3..8 to bits 10..15 (link up, link down, page received, duplex change, speed change, negotiation error). The bit latches whether or not its mask bit is set.
- R3: A read of 0x13 returns the pending bits in the same cycle as `reg_rd_i`, and at the next clock edge it clears every bit it returned.
- R4: An event pulse in the same cycle as a read of 0x13 leaves its bit set after that read.
- R5: `irq_no` is low in the cycle after a clock edge at which pending AND mask is non-zero, and high in the cycle after an edge at which it is zero.
- R6: Writing zero to the mask register releases `irq_no` one cycle later. Bits that are already pending stay readable and are cleared by a later read.
- R7: Writes to 0x13 are ignored. Unused positions in both registers read as zero.
- R8: After reset, both registers read zero and `irq_no` is high.
- R9: A read of any other address returns zero and leaves the pending bits untouched. `reg_rdata_o` is zero whenever `reg_rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 5 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, valid while `reg_rd_i` is high |
| evt_i | input | 9 | Event pulses, one per source |
| irq_no | output | 1 | Interrupt, active low |

## Verification
The bench sweeps every event source, once with its mask bit set and once with it clear, and every single-bit mask write. These sweeps would catch a wrong bit map, a pending bit that only latches when unmasked, or an unused position that retains data. It times the line to the exact cycle: a design that drives the line from logic without the register, or that clears it one cycle late, fails the edge checks. Two races are probed directly: an event arriving in the same cycle as the acknowledging read, which a design with a plain clear would lose, and a write to the pending address, which a design with writable pending bits would let erase an event. A read of an unrelated address must not clear anything.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  parameter int DATA_W  = 16;
  parameter int ADDR_W  = 5;
  parameter int EVT_N   = 9;
  parameter logic [ADDR_W-1:0] MASK_ADDR = 5'h12;
  parameter logic [ADDR_W-1:0] PEND_ADDR = 5'h13;

  // bit position of event k in the register layout
  function automatic int evt_pos(input int k);
    if (k < 2)       return k;
    else if (k == 2) return 5;
    else             return k + 7;
  endfunction

  function automatic logic [DATA_W-1:0] valid_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int k = 0; k < EVT_N; k++) m[evt_pos(k)] = 1'b1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] map_events(input logic [EVT_N-1:0] e);
    logic [DATA_W-1:0] v;
    v = '0;
    for (int k = 0; k < EVT_N; k++) v[evt_pos(k)] = e[k];
    return v;
  endfunction
endpackage

// File: rtl/phy_irq_evt_map.sv
module phy_irq_evt_map
  import phy_irq_pkg::*;
(
  input  logic [EVT_N-1:0]  evt_i,
  output logic [DATA_W-1:0] vec_o
);
  localparam logic [DATA_W-1:0] VALID = valid_mask();

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (VALID[b]) begin : g_used
      logic hit;
      always_comb begin
        hit = 1'b0;
        for (int k = 0; k < EVT_N; k++)
          if (evt_pos(k) == b) hit = hit | evt_i[k];
      end
      assign vec_o[b] = hit;
    end else begin : g_unused
      assign vec_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/phy_irq_pend.sv
module phy_irq_pend
  import phy_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] set_i,
  input  logic              ack_i,
  output logic [DATA_W-1:0] pend_o
);
  logic [DATA_W-1:0] pend_q;

  // an ack drops what was read; a same-cycle set survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= '0;
    else if (ack_i) pend_q <= set_i;
    else            pend_q <= pend_q | set_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/phy_irq_line.sv
module phy_irq_line
  import phy_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] pend_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic              irq_no
);
  logic active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= 1'b0;
    else         active_q <= |(pend_i & mask_i);
  end

  assign irq_no = ~active_q;
endmodule

// File: rtl/phy_irq_agg.sv
module phy_irq_agg
  import phy_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [EVT_N-1:0]  evt_i,
  output logic              irq_no
);
  localparam logic [DATA_W-1:0] VALID = valid_mask();

  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] pend;
  logic [DATA_W-1:0] evt_vec;
  logic              sel_mask;
  logic              sel_pend;
  logic              ack;

  assign sel_mask = (reg_addr_i == MASK_ADDR);
  assign sel_pend = (reg_addr_i == PEND_ADDR);
  assign ack      = reg_rd_i & sel_pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  mask_q <= '0;
    else if (reg_wr_i && sel_mask) mask_q <= reg_wdata_i & VALID;
  end

  phy_irq_evt_map u_map (
    .evt_i (evt_i),
    .vec_o (evt_vec)
  );

  phy_irq_pend u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_vec),
    .ack_i  (ack),
    .pend_o (pend)
  );

  phy_irq_line u_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend),
    .mask_i (mask_q),
    .irq_no (irq_no)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_rd_i) begin
      if (sel_mask)      reg_rdata_o = mask_q;
      else if (sel_pend) reg_rdata_o = pend;
    end
  end
endmodule

// File: rtl/phy_irq_agg_chk.sv
module phy_irq_agg_chk
  import phy_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [EVT_N-1:0]  evt_i,
  input logic              irq_no,
  input logic [DATA_W-1:0] pend,
  input logic [DATA_W-1:0] mask_q
);
  localparam logic [DATA_W-1:0] VALID = valid_mask();

  p_mask_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == MASK_ADDR) |=> mask_q == ($past(reg_wdata_i) & VALID));

  p_evt_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((pend & $past(map_events(evt_i))) == $past(map_events(evt_i))));

  p_read_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == PEND_ADDR && evt_i == '0) |=> pend == '0);

  p_race_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == PEND_ADDR) |=> pend == $past(map_events(evt_i)));

  p_irq_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend & mask_q) != '0) |=> !irq_no);

  p_irq_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend & mask_q) == '0) |=> irq_no);

  p_unused_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend | mask_q) & ~VALID) == '0);

  p_other_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i != PEND_ADDR) |=> ((pend & $past(pend)) == $past(pend)));
endmodule

bind phy_irq_agg phy_irq_agg_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_wdata_i (reg_wdata_i),
  .evt_i       (evt_i),
  .irq_no      (irq_no),
  .pend        (pend),
  .mask_q      (mask_q)
);

// File: tb/phy_irq_agg_test.sv
module phy_irq_agg_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_MASK = 5'h12;
  localparam logic [4:0] A_PEND = 5'h13;
  localparam logic [15:0] VALID = 16'hFC23;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [8:0]  evt = '0;
  logic        irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_irq_agg uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_addr_i  (addr),
    .reg_wr_i    (wr),
    .reg_rd_i    (rd),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .evt_i       (evt),
    .irq_no      (irq_n)
  );

  function automatic int pos_of(input int k);
    case (k)
      0: return 0;
      1: return 1;
      2: return 5;
      default: return 10 + (k - 3);
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1;
    tick();
    wr = 1'b0; wdata = '0;
  endtask

  // sample combinational read data, then let the access commit
  task automatic rd_reg(input logic [4:0] a, output logic [15:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    tick();
    rd = 1'b0;
  endtask

  task automatic pulse(input logic [8:0] e);
    evt = e;
    tick();
    evt = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] exp;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R8 reset state
    chk(irq_n === 1'b1, "R8 irq idle", {15'h0, irq_n}, 16'h1);
    rd_reg(A_MASK, v); chk(v === 16'h0, "R8 mask reset", v, 16'h0);
    rd_reg(A_PEND, v); chk(v === 16'h0, "R8 pend reset", v, 16'h0);
    chk(rdata === 16'h0, "R9 rdata idle", rdata, 16'h0);

    // R1 / R7 single-bit mask sweep
    for (int b = 0; b < 16; b++) begin
      wr_reg(A_MASK, 16'h1 << b);
      rd_reg(A_MASK, v);
      exp = (16'h1 << b) & VALID;
      chk(v === exp, "R1 R7 mask bit", v, exp);
    end
    wr_reg(A_MASK, 16'hFFFF);
    rd_reg(A_MASK, v); chk(v === VALID, "R1 mask all", v, VALID);

    // R2 R3 R5 per-event sweep, masked and unmasked
    for (int k = 0; k < 9; k++) begin
      for (int en = 0; en < 2; en++) begin
        exp = 16'h1 << pos_of(k);
        wr_reg(A_MASK, en != 0 ? exp : (VALID & ~exp));
        pulse(9'h1 << k);
        chk(irq_n === 1'b1, "R5 irq registered", {15'h0, irq_n}, 16'h1);
        tick();
        chk(irq_n === (en == 0), "R5 irq assert", {15'h0, irq_n}, {15'h0, en == 0});
        rd_reg(A_PEND, v);
        chk(v === exp, "R2 pend bit", v, exp);
        tick();
        chk(irq_n === 1'b1, "R5 irq release", {15'h0, irq_n}, 16'h1);
        rd_reg(A_PEND, v);
        chk(v === 16'h0, "R3 cleared by read", v, 16'h0);
      end
    end

    // R2 all events together
    wr_reg(A_MASK, 16'h0);
    pulse(9'h1FF);
    rd_reg(A_PEND, v); chk(v === VALID, "R2 all events", v, VALID);

    // R4 event racing the acknowledge
    pulse(9'h001);
    addr = A_PEND; rd = 1'b1; evt = 9'h010;
    #1 v = rdata;
    chk(v === 16'h0001, "R4 read old value", v, 16'h0001);
    tick();
    rd = 1'b0; evt = '0;
    rd_reg(A_PEND, v); chk(v === 16'h0800, "R4 race kept", v, 16'h0800);

    // R6 masking everything releases line, pending survives
    wr_reg(A_MASK, VALID);
    pulse(9'h010);
    tick();
    chk(irq_n === 1'b0, "R6 irq active", {15'h0, irq_n}, 16'h0);
    wr_reg(A_MASK, 16'h0);
    chk(irq_n === 1'b0, "R6 irq one cycle", {15'h0, irq_n}, 16'h0);
    tick();
    chk(irq_n === 1'b1, "R6 irq released", {15'h0, irq_n}, 16'h1);
    rd_reg(A_PEND, v); chk(v === 16'h0800, "R6 pend kept", v, 16'h0800);
    rd_reg(A_PEND, v); chk(v === 16'h0, "R6 pend cleared", v, 16'h0);

    // R7 writes to pending address ignored
    wr_reg(A_PEND, 16'hFFFF);
    rd_reg(A_PEND, v); chk(v === 16'h0, "R7 pend write set", v, 16'h0);
    pulse(9'h100);
    wr_reg(A_PEND, 16'h0);
    rd_reg(A_PEND, v); chk(v === 16'h8000, "R7 pend write clear", v, 16'h8000);

    // R9 foreign address read
    pulse(9'h004);
    rd_reg(5'h00, v); chk(v === 16'h0, "R9 other addr data", v, 16'h0);
    rd_reg(5'h11, v); chk(v === 16'h0, "R9 other addr data", v, 16'h0);
    rd_reg(A_PEND, v); chk(v === 16'h0020, "R9 pend untouched", v, 16'h0020);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule